// File: doc/BRIEF.md
# Mode Change Interrupt Generator

This block sits behind a video mode detector. It watches eight results that the detector reports: one sync-jitter flag, three numeric measurements and four single-bit flags. The numeric measurements are the line count per frame, the frame length in clocks and the line length in clocks. The four flags are missing vertical sync, missing horizontal sync, vertical sync polarity and horizontal sync polarity.

Each time the detector pulses its update strobe, the block compares the new results with a held reference copy. A single-bit flag counts as changed on any difference. A numeric measurement counts as changed only when it has moved by more than a fixed margin, so that normal measurement noise is ignored. Each change sets a sticky status bit. The host clears status bits by pulsing write-one-to-clear lines. A level interrupt is raised while any status bit is set whose enable bit is also set.

Top module: `mode_irq_gen`

## Requirements
- R1: After reset, `status` is 0, `irq` is 0, and the block is unprimed.
- R2: The first `meas_upd` after reset loads every reference from the inputs and sets no status bit.
- R3: On a later `meas_upd`, a numeric item sets its status bit in the clock after the strobe only when the absolute difference between the input and the reference exceeds DELTA (default 4). The difference is taken in both directions, so a difference of exactly 4 does not fire and a difference of 5 does.
- R4: A numeric reference is replaced by the input only on a strobe on which that item fires. Repeated drift of DELTA or less per strobe therefore fires once the accumulated drift exceeds DELTA.
- R5: A single-bit item (jitter, missing vertical sync, missing horizontal sync, vertical polarity, horizontal polarity) sets its status bit on a strobe whenever the input differs from the reference. Its reference follows the input on every strobe.
- R6: While `meas_upd` is low, input changes set no status bit and leave the references unchanged.
- R7: Status bits are sticky. A 1 on `clr_w1c[i]` clears `status[i]` in the next clock, and bits written with 0 are kept.
- R8: If an event on item i and a clear of bit i occur in the same cycle, the event wins and `status[i]` stays 1.
- R9: The status bit positions are: 0 jitter, 1 line count, 2 frame clocks, 3 line clocks, 4 missing vertical sync, 5 missing horizontal sync, 6 vertical polarity, 7 horizontal polarity. A status bit is set whether or not its enable is set. `irq` is high exactly when some bit of `status & int_en` is 1, and it follows `int_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_upd | input | 1 | One-cycle strobe: new detector results are valid |
| meas_jitter | input | 1 | Sync edges coincide (possible jitter) |
| meas_lines | input | LINES_W | Lines per frame |
| meas_frame_clks | input | FRAME_W | Frame length in clocks |
| meas_line_clks | input | HCLK_W | Line length in clocks |
| meas_no_vs | input | 1 | Vertical sync missing |
| meas_no_hs | input | 1 | Horizontal sync missing |
| meas_vs_pol | input | 1 | Vertical sync active high |
| meas_hs_pol | input | 1 | Horizontal sync active high |
| int_en | input | 8 | Per-item interrupt enables |
| clr_w1c | input | 8 | Write-one-to-clear pulses for status |
| status | output | 8 | Sticky change status bits |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can fall in the same cycle: a host clear of a status bit, and a strobe that detects a new change on the same item. The bench issues `clr_w1c` together with a `meas_upd` carrying a line-count jump of more than 4, and in the same cycle clears bits whose items do not change. It then judges per bit that the changed item stays set while the other cleared bits drop. A behavioural model that keeps its references as integers is compared with `status` and `irq` on every clock.

// File: rtl/mode_irq_gen.sv
module mode_irq_gen #(
  parameter int LINES_W = 12,
  parameter int FRAME_W = 24,
  parameter int HCLK_W  = 17,
  parameter int DELTA   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               meas_upd,
  input  logic               meas_jitter,
  input  logic [LINES_W-1:0] meas_lines,
  input  logic [FRAME_W-1:0] meas_frame_clks,
  input  logic [HCLK_W-1:0]  meas_line_clks,
  input  logic               meas_no_vs,
  input  logic               meas_no_hs,
  input  logic               meas_vs_pol,
  input  logic               meas_hs_pol,
  input  logic [7:0]         int_en,
  input  logic [7:0]         clr_w1c,
  output logic [7:0]         status,
  output logic               irq
);

  logic               primed;
  logic [LINES_W-1:0] ref_lines;
  logic [FRAME_W-1:0] ref_frame;
  logic [HCLK_W-1:0]  ref_hclk;
  logic [4:0]         ref_flags;
  logic [4:0]         cur_flags;
  logic [LINES_W-1:0] d_lines;
  logic [FRAME_W-1:0] d_frame;
  logic [HCLK_W-1:0]  d_hclk;
  logic [2:0]         big;
  logic [4:0]         flip;
  logic [7:0]         hit;

  assign cur_flags = {meas_hs_pol, meas_vs_pol, meas_no_hs, meas_no_vs, meas_jitter};

  assign d_lines = (meas_lines >= ref_lines) ? meas_lines - ref_lines : ref_lines - meas_lines;
  assign d_frame = (meas_frame_clks >= ref_frame) ? meas_frame_clks - ref_frame
                                                  : ref_frame - meas_frame_clks;
  assign d_hclk  = (meas_line_clks >= ref_hclk) ? meas_line_clks - ref_hclk
                                                : ref_hclk - meas_line_clks;

  assign big[0] = int'(d_lines) > DELTA;
  assign big[1] = int'(d_frame) > DELTA;
  assign big[2] = int'(d_hclk)  > DELTA;
  assign flip   = cur_flags ^ ref_flags;

  assign hit = {flip[4:1], big[2:0], flip[0]} & {8{meas_upd & primed}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      status    <= '0;
      ref_lines <= '0;
      ref_frame <= '0;
      ref_hclk  <= '0;
      ref_flags <= '0;
    end else begin
      status <= (status & ~clr_w1c) | hit;
      if (meas_upd) begin
        primed    <= 1'b1;
        ref_flags <= cur_flags;
        if (!primed || big[0]) ref_lines <= meas_lines;
        if (!primed || big[1]) ref_frame <= meas_frame_clks;
        if (!primed || big[2]) ref_hclk  <= meas_line_clks;
      end
    end
  end

  assign irq = |(status & int_en);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status & $past(status & ~clr_w1c)) == $past(status & ~clr_w1c)));

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_upd |=> (status == $past(status & ~clr_w1c)));

  // R6
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_upd |=> ($stable(ref_lines) && $stable(ref_frame) && $stable(ref_hclk) && $stable(ref_flags)));

  // R5
  vspol_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_upd && primed && (meas_vs_pol != ref_flags[3])) |=> status[6]);

  // R2
  prime_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_upd && !primed) |=> ((status & ~$past(status)) == 8'd0));

endmodule

// File: tb/mode_irq_gen_tb.sv
module mode_irq_gen_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic upd = 0;
  logic jit = 0, nvs = 0, nhs = 0, vsp = 0, hsp = 0;
  logic [11:0] lines = 0;
  logic [23:0] frame = 0;
  logic [16:0] hclk = 0;
  logic [7:0] en = 0, clr = 0;
  logic [7:0] status;
  logic irq;

  always #5 clk = ~clk;

  mode_irq_gen u_dut (
    .clk(clk), .rst_n(rst_n), .meas_upd(upd), .meas_jitter(jit),
    .meas_lines(lines), .meas_frame_clks(frame), .meas_line_clks(hclk),
    .meas_no_vs(nvs), .meas_no_hs(nhs), .meas_vs_pol(vsp), .meas_hs_pol(hsp),
    .int_en(en), .clr_w1c(clr), .status(status), .irq(irq)
  );

  int vectors = 0, fails = 0;
  bit done = 0;
  bit m_primed = 0;
  int m_ref[3];
  bit m_fref[5];
  bit [7:0] m_st = 0;

  task automatic compare(string tag);
    bit m_irq;
    m_irq = 0;
    for (int i = 0; i < 8; i++) if (m_st[i] && en[i]) m_irq = 1;
    vectors++;
    if (status !== m_st) begin
      fails++;
      $display("FAIL %s status=%b expected=%b", tag, status, m_st);
    end
    if (irq !== m_irq) begin
      fails++;
      $display("FAIL %s irq=%b expected=%b", tag, irq, m_irq);
    end
  endtask

  task automatic model_edge();
    int cur[3];
    bit fc[5];
    bit [7:0] ev;
    int d;
    cur[0] = int'(lines); cur[1] = int'(frame); cur[2] = int'(hclk);
    fc[0] = jit; fc[1] = nvs; fc[2] = nhs; fc[3] = vsp; fc[4] = hsp;
    ev = 0;
    if (upd) begin
      if (m_primed) begin
        for (int k = 0; k < 3; k++) begin
          d = cur[k] - m_ref[k];
          if (d < 0) d = -d;
          if (d > 4) begin ev[k+1] = 1; m_ref[k] = cur[k]; end
        end
        if (fc[0] != m_fref[0]) ev[0] = 1;
        for (int k = 1; k < 5; k++) if (fc[k] != m_fref[k]) ev[k+3] = 1;
      end else begin
        for (int k = 0; k < 3; k++) m_ref[k] = cur[k];
      end
      for (int k = 0; k < 5; k++) m_fref[k] = fc[k];
      m_primed = 1;
    end
    m_st = (m_st & ~clr) | ev;
  endtask

  task automatic step(string tag, bit u, bit [7:0] c);
    upd = u; clr = c;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
    upd = 0; clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    compare("R1");
    step("R1", 0, 0);

    // R2: priming strobe
    lines = 768; frame = 600000; hclk = 1344; vsp = 1; nhs = 0;
    step("R2", 1, 0);
    en = 8'hFF;
    step("R2", 0, 0);

    // R3: threshold in both directions
    lines = 772; step("R3", 1, 0);
    lines = 773; step("R3", 1, 0);
    step("R7", 0, 8'h02);
    lines = 768; step("R3", 1, 0);
    frame = 599996; step("R3", 1, 0);
    frame = 599995; step("R3", 1, 0);
    step("R7", 0, 8'hFF);

    // R4: drift accumulates against a held reference
    hclk = 1347; step("R4", 1, 0);
    hclk = 1350; step("R4", 1, 0);
    hclk = 1353; step("R4", 1, 0);
    step("R7", 0, 8'h08);

    // R5: flags fire on any change
    jit = 1; step("R5", 1, 0);
    nvs = 1; nhs = 1; step("R5", 1, 0);
    vsp = 0; hsp = 1; step("R5", 1, 0);
    step("R5", 1, 0);
    step("R7", 0, 8'hFF);
    jit = 0; step("R5", 1, 0);
    step("R7", 0, 8'h01);

    // R6: no strobe, no effect
    lines = 100; frame = 5; hclk = 9000; nvs = 0; vsp = 1;
    for (int i = 0; i < 4; i++) step("R6", 0, 0);
    lines = 768; frame = 599995; hclk = 1353; nvs = 1; vsp = 0;
    step("R6", 1, 0);

    // R7: partial clear
    jit = 1; nhs = 0; step("R7", 1, 0);
    step("R7", 0, 8'h01);
    step("R7", 0, 8'h00);
    step("R7", 0, 8'h20);

    // R8: event and clear in the same cycle
    jit = 0; step("R8", 1, 0);
    lines = 800; step("R8", 1, 8'h03);
    step("R8", 0, 0);
    step("R7", 0, 8'hFF);

    // R9: status set while disabled, irq follows enable
    en = 8'h00;
    hsp = 0; step("R9", 1, 0);
    step("R9", 0, 0);
    en = 8'h7F; step("R9", 0, 0);
    en = 8'h80; step("R9", 0, 0);
    step("R9", 0, 8'h80);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired status=%b expected=done", status);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule